// File: doc/BRIEF.md
# Palette DAC Host Register Port

This block is the host-side register front end of a colour palette converter. It holds a 256-entry RGB colour table, two cursor colours and four byte-wide control registers. Software reaches all of them through four word-wide registers: an index register, a colour-table data register, a control data register and a cursor-colour data register. Each register carries its byte in the most significant byte lane of the bus word. The other 24 bits are ignored on writes and read back as zero.

A colour entry is written as three data writes: red, then green, then blue. The third write stores the whole entry at once and moves the index on to the next entry. One index write can therefore start a stream of entries. The same index register picks a cursor colour (index 2 or 3) or a control register (index 4 to 7).

On the display side, a registered lookup turns an 8-bit pixel index into a 24-bit colour. A two-bit select can replace that colour with one of the two cursor colours. The select only takes effect while bit 0 of control register 6 is set.

Top module: `pal_dac_port`

## Requirements
- R1: Writes use only bits 31:24 of `host_wdata`, and bits 23:0 have no effect. Every read returns its byte in bits 31:24 of `host_rdata` with bits 23:0 zero. `host_rdata` is loaded at the clock edge that samples `host_rd` and holds until the next read. If `host_wr` and `host_rd` are both high, only the write is performed.
- R2: The register is chosen by `host_reg`: 0 = index, 1 = colour-table data, 2 = control data, 3 = cursor data. A write to the index register loads the index. A read of the index register returns the current index.
- R3: Writes to the colour-table register go through three sub-steps in the order red, green, blue. The blue write stores the entry {red, green, blue} at the current index. In the pixel output, red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R4: Each completed triple adds one to the index. Index 255 wraps to 0.
- R5: Any write to the index register returns the sub-step to red, so a half-written triple is dropped.
- R6: Reads of the colour-table register return the stored entry's red, green and blue bytes in turn. They use the same sub-step sequence as writes, and the index advances after the blue read.
- R7: Cursor-data triples store cursor colour 0 when the index is 2 and cursor colour 1 when the index is 3. A completed triple advances the index. A cursor-data write at any other index is ignored and changes no state. Reads of the cursor register return 0.
- R8: Control-data writes at index 4 to 7 load that control register, and reads at those indices return it. Control accesses never move the index or the sub-step. Control writes at other indices are ignored, and control reads there return 0. All control registers reset to 0.
- R9: `cursor_en` equals bit 0 of control register 6. While it is high, `pix_sel` 1 outputs cursor colour 0 and `pix_sel` 2 outputs cursor colour 1. `pix_sel` 0 and 3 output the colour-table entry. While `cursor_en` is low, every select outputs the colour-table entry.
- R10: `pix_rgb` is registered. It shows the lookup of the inputs sampled at the previous edge. A host store made at one edge is visible in `pix_rgb` after the next edge.
- R11: Reset clears the index to 0 and the sub-step to red. It also clears the cursor colours, the control registers, `host_rdata` and `pix_rgb`. Colour-table contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_reg | input | 2 | Register select (0 index, 1 colour table, 2 control, 3 cursor) |
| host_wdata | input | 32 | Write word; byte in bits 31:24 |
| host_rdata | output | 32 | Read word; byte in bits 31:24 |
| pix_index | input | 8 | Pixel colour-table index |
| pix_sel | input | 2 | Pixel cursor select (0 table, 1 cursor 0, 2 cursor 1, 3 table) |
| pix_rgb | output | 24 | Registered pixel colour {R,G,B} |
| cursor_en | output | 1 | Cursor overlay enable (control register 6, bit 0) |

## Verification
The bench uses the default 32-bit bus, with the byte lane at bits 31:24 and an 8-bit index, so all 256 colour-table entries can be covered. Every entry is filled from a single index write with garbage in the low bus bits. The table is then checked through both the pixel port and streamed host reads. Because the index width is small, the 255-to-0 wrap, a dropped half-triple and a store racing a pixel lookup all fit in a short run. Every control index, every cursor index and an out-of-range index are also exercised.

// File: rtl/dac_pkg.sv
package dac_pkg;

    localparam int LANE_W        = 8;
    localparam int CURS_BASE     = 2;
    localparam int CURS_NUM      = 2;
    localparam int CTRL_BASE     = 4;
    localparam int CTRL_NUM      = 4;
    localparam int CTRL_CURS_REG = 6;
    localparam int CURS_EN_BIT   = 0;

    typedef enum logic [1:0] {
        STEP_R = 2'd0,
        STEP_G = 2'd1,
        STEP_B = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        REG_INDEX = 2'd0,
        REG_CMAP  = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CURS  = 2'd3
    } hreg_e;

    typedef enum logic [1:0] {
        SEL_TABLE  = 2'd0,
        SEL_CUR0   = 2'd1,
        SEL_CUR1   = 2'd2,
        SEL_TABLE2 = 2'd3
    } psel_e;

    typedef struct packed {
        logic [LANE_W-1:0] r;
        logic [LANE_W-1:0] g;
        logic [LANE_W-1:0] b;
    } rgb_t;

    function automatic step_e step_after(input step_e s);
        case (s)
            STEP_R:  return STEP_G;
            STEP_G:  return STEP_B;
            default: return STEP_R;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] pick_component(input rgb_t c, input step_e s);
        case (s)
            STEP_R:  return c.r;
            STEP_G:  return c.g;
            default: return c.b;
        endcase
    endfunction

endpackage

// File: rtl/dac_index_seq.sv
module dac_index_seq
    import dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step_go,
    output logic [IDX_W-1:0] idx,
    output step_e            step,
    output logic             triple_done
);

    logic [IDX_W-1:0] idx_q;
    step_e            step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            step_q <= STEP_R;
        end else if (load) begin
            idx_q  <= load_val;
            step_q <= STEP_R;
        end else if (step_go) begin
            step_q <= step_after(step_q);
            if (step_q == STEP_B) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idx         = idx_q;
    assign step        = step_q;
    assign triple_done = step_go && (step_q == STEP_B);

endmodule

// File: rtl/dac_colour_store.sv
module dac_colour_store
    import dac_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int N_CURS  = CURS_NUM
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tbl_we,
    input  logic                       cur_we,
    input  logic [$clog2(N_CURS)-1:0]  cur_slot,
    input  step_e                      step,
    input  logic [IDX_W-1:0]           idx,
    input  logic [LANE_W-1:0]          wbyte,
    output logic [LANE_W-1:0]          rd_byte,
    input  logic [IDX_W-1:0]           pix_index,
    input  logic [1:0]                 pix_sel,
    input  logic                       overlay_on,
    output rgb_t                       pix_rgb
);

    localparam int DEPTH = 1 << IDX_W;

    rgb_t              tbl_mem [DEPTH];
    rgb_t              curs_q  [N_CURS];
    logic [LANE_W-1:0] stage_r;
    logic [LANE_W-1:0] stage_g;
    rgb_t              commit_val;
    rgb_t              pix_next;
    rgb_t              pix_q;
    logic              any_we;

    assign any_we     = tbl_we || cur_we;
    assign commit_val = '{r: stage_r, g: stage_g, b: wbyte};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_r <= '0;
            stage_g <= '0;
        end else if (any_we) begin
            if (step == STEP_R) stage_r <= wbyte;
            if (step == STEP_G) stage_g <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (tbl_we && step == STEP_B) begin
            tbl_mem[idx] <= commit_val;
        end
    end

    for (genvar s = 0; s < N_CURS; s++) begin : g_curs
        always_ff @(posedge clk) begin
            if (rst) begin
                curs_q[s] <= '0;
            end else if (cur_we && step == STEP_B && cur_slot == s) begin
                curs_q[s] <= commit_val;
            end
        end
    end

    assign rd_byte = pick_component(tbl_mem[idx], step);

    always_comb begin
        pix_next = tbl_mem[pix_index];
        if (overlay_on) begin
            case (psel_e'(pix_sel))
                SEL_CUR0: pix_next = curs_q[0];
                SEL_CUR1: pix_next = curs_q[N_CURS-1];
                default:  pix_next = tbl_mem[pix_index];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pix_q <= '0;
        else     pix_q <= pix_next;
    end

    assign pix_rgb = pix_q;

endmodule

// File: rtl/dac_ctrl_bank.sv
module dac_ctrl_bank
    import dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int N_CTRL = CTRL_NUM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] wbyte,
    output logic [LANE_W-1:0] rd_byte,
    output logic              overlay_on
);

    localparam int OFF_W = $clog2(N_CTRL);

    logic [LANE_W-1:0] ctrl_q [N_CTRL];
    logic              hit;
    logic [OFF_W-1:0]  off;
    logic [IDX_W-1:0]  rel;

    assign rel = idx - IDX_W'(CTRL_BASE);
    assign hit = (idx >= IDX_W'(CTRL_BASE)) && (idx < IDX_W'(CTRL_BASE + N_CTRL));
    assign off = rel[OFF_W-1:0];

    for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[k] <= '0;
            end else if (we && hit && off == k) begin
                ctrl_q[k] <= wbyte;
            end
        end
    end

    assign rd_byte    = hit ? ctrl_q[off] : '0;
    assign overlay_on = ctrl_q[CTRL_CURS_REG - CTRL_BASE][CURS_EN_BIT];

endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
    import dac_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_reg,
    input  logic [BUS_W-1:0]  host_wdata,
    output logic [BUS_W-1:0]  host_rdata,
    input  logic [LANE_W-1:0] pix_index,
    input  logic [1:0]        pix_sel,
    output logic [3*LANE_W-1:0] pix_rgb,
    output logic              cursor_en
);

    localparam int LANE_LSB = BUS_W - LANE_W;
    localparam int IDX_W    = LANE_W;
    localparam int SLOT_W   = $clog2(CURS_NUM);

    logic [LANE_W-1:0]   wbyte;
    logic                unused_low_bits;
    logic                rd_en;
    logic                wr_index, wr_cmap, wr_ctrl, wr_curs, rd_cmap;
    logic                curs_hit;
    logic                step_go;
    logic [IDX_W-1:0]    idx_q;
    step_e               step_q;
    logic                triple_done;
    logic [SLOT_W-1:0]   cur_slot;
    logic [IDX_W-1:0]    cur_rel;
    logic [LANE_W-1:0]   tbl_rd_byte;
    logic [LANE_W-1:0]   ctrl_rd_byte;
    logic [LANE_W-1:0]   rd_sel_byte;
    logic [BUS_W-1:0]    rdata_q;
    rgb_t                pix_val;
    logic                overlay_on;
    hreg_e               reg_sel;

    assign reg_sel         = hreg_e'(host_reg);
    assign wbyte           = host_wdata[BUS_W-1:LANE_LSB];
    assign unused_low_bits = ^host_wdata[LANE_LSB-1:0];
    assign rd_en           = host_rd && !host_wr;

    assign wr_index = host_wr && (reg_sel == REG_INDEX);
    assign wr_cmap  = host_wr && (reg_sel == REG_CMAP);
    assign wr_ctrl  = host_wr && (reg_sel == REG_CTRL);
    assign wr_curs  = host_wr && (reg_sel == REG_CURS) && curs_hit;
    assign rd_cmap  = rd_en   && (reg_sel == REG_CMAP);

    assign curs_hit = (idx_q >= IDX_W'(CURS_BASE)) && (idx_q < IDX_W'(CURS_BASE + CURS_NUM));
    assign cur_rel  = idx_q - IDX_W'(CURS_BASE);
    assign cur_slot = cur_rel[SLOT_W-1:0];
    assign step_go  = wr_cmap || wr_curs || rd_cmap;

    dac_index_seq #(.IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .load        (wr_index),
        .load_val    (wbyte),
        .step_go     (step_go),
        .idx         (idx_q),
        .step        (step_q),
        .triple_done (triple_done)
    );

    dac_colour_store #(.IDX_W(IDX_W), .N_CURS(CURS_NUM)) u_store (
        .clk        (clk),
        .rst        (rst),
        .tbl_we     (wr_cmap),
        .cur_we     (wr_curs),
        .cur_slot   (cur_slot),
        .step       (step_q),
        .idx        (idx_q),
        .wbyte      (wbyte),
        .rd_byte    (tbl_rd_byte),
        .pix_index  (pix_index),
        .pix_sel    (pix_sel),
        .overlay_on (overlay_on),
        .pix_rgb    (pix_val)
    );

    dac_ctrl_bank #(.IDX_W(IDX_W), .N_CTRL(CTRL_NUM)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .we         (wr_ctrl),
        .idx        (idx_q),
        .wbyte      (wbyte),
        .rd_byte    (ctrl_rd_byte),
        .overlay_on (overlay_on)
    );

    always_comb begin
        case (reg_sel)
            REG_INDEX: rd_sel_byte = idx_q;
            REG_CMAP:  rd_sel_byte = tbl_rd_byte;
            REG_CTRL:  rd_sel_byte = ctrl_rd_byte;
            default:   rd_sel_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= {rd_sel_byte, {LANE_LSB{1'b0}}};
    end

    assign host_rdata = rdata_q;
    assign pix_rgb    = pix_val;
    assign cursor_en  = overlay_on;

endmodule

// File: rtl/dac_port_chk.sv
module dac_port_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_reg,
    input logic [BUS_W-1:0] host_wdata,
    input logic [BUS_W-1:0] host_rdata,
    input logic             cursor_en,
    input logic [7:0]       idx,
    input logic [1:0]       step
);

    a_r1_rdata_lane: assert property (@(posedge clk) disable iff (rst)
        host_rdata[BUS_W-9:0] == '0);

    a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_reg == 2'd0) |=> (idx == $past(host_wdata[BUS_W-1:BUS_W-8]) && step == 2'd0));

    a_r3_step_legal: assert property (@(posedge clk) disable iff (rst)
        step != 2'd3);

    a_r4_triple_advance: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_reg == 2'd1 && step == 2'd2) |=> (idx == $past(idx) + 8'd1 && step == 2'd0));

    a_r6_read_step: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && host_reg == 2'd1 && step != 2'd2) |=> (idx == $past(idx) && step == $past(step) + 2'd1));

    a_r8_ctrl_quiet: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_reg == 2'd2) |=> $stable(cursor_en));

    a_r8_ctrl_keeps_index: assert property (@(posedge clk) disable iff (rst)
        (host_reg == 2'd2 && (host_wr || host_rd)) |=> (idx == $past(idx) && step == $past(step)));

    a_r9_enable_write: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_reg == 2'd2 && idx == 8'd6) |=> cursor_en == $past(host_wdata[BUS_W-8]));

endmodule

bind pal_dac_port dac_port_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_reg   (host_reg),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cursor_en  (cursor_en),
    .idx        (idx_q),
    .step       (step_q)
);

// File: tb/pal_dac_port_tb.sv
`timescale 1ns/1ps
module pal_dac_port_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr, host_rd;
    logic [1:0]  host_reg;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic [7:0]  pix_index;
    logic [1:0]  pix_sel;
    logic [23:0] pix_rgb;
    logic        cursor_en;

    int n_chk  = 0;
    int n_fail = 0;
    logic [23:0] exp_tbl [256];

    always #2.5 clk = ~clk;

    pal_dac_port u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_index(pix_index), .pix_sel(pix_sel), .pix_rgb(pix_rgb),
        .cursor_en(cursor_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] r, input logic [7:0] b, input logic [23:0] junk);
        @(negedge clk);
        host_wr = 1'b1; host_reg = r; host_wdata = {b, junk};
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic hread(input logic [1:0] r, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_reg = r;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic pixel(input logic [7:0] i, input logic [1:0] s, output logic [23:0] v);
        @(negedge clk);
        pix_index = i; pix_sel = s;
        @(negedge clk);
        v = pix_rgb;
    endtask

    function automatic logic [23:0] pattern(input int i);
        logic [7:0] x;
        x = 8'(i);
        return {x, x ^ 8'h5A, ~x};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [23:0] v, v_old;
        int errs;
        rst = 1'b1; host_wr = 0; host_rd = 0; host_reg = 0; host_wdata = 0;
        pix_index = 0; pix_sel = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check("R11 pix_rgb reset", {8'h0, pix_rgb}, 32'h0);
        check("R11 rdata reset", host_rdata, 32'h0);
        check("R11 cursor_en reset", {31'h0, cursor_en}, 32'h0);
        hread(2'd0, d);
        check("R11 index reset", d, 32'h0);

        // R1 R3 R4: fill whole table from one index write, junk in low lanes
        hwrite(2'd0, 8'h00, 24'hABCDEF);
        for (int i = 0; i < 256; i++) begin
            exp_tbl[i] = pattern(i);
            hwrite(2'd1, exp_tbl[i][23:16], 24'(i * 7));
            hwrite(2'd1, exp_tbl[i][15:8],  24'hFFFFFF);
            hwrite(2'd1, exp_tbl[i][7:0],   24'h123456);
        end
        hread(2'd0, d);
        check("R4 index wrapped after 256 triples", d, 32'h0);

        errs = 0;
        for (int i = 0; i < 256; i++) begin
            pixel(8'(i), 2'd0, v);
            n_chk++;
            if (v !== exp_tbl[i]) begin
                n_fail++; errs++;
                $display("FAIL R3 pixel %0d: actual %h expected %h", i, v, exp_tbl[i]);
            end
        end

        // R6 streamed reads
        hwrite(2'd0, 8'h00, 24'h0);
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) begin
                logic [7:0] e;
                e = (c == 0) ? exp_tbl[i][23:16] : (c == 1) ? exp_tbl[i][15:8] : exp_tbl[i][7:0];
                hread(2'd1, d);
                n_chk++;
                if (d !== {e, 24'h0}) begin
                    n_fail++;
                    $display("FAIL R6 read entry %0d comp %0d: actual %h expected %h", i, c, d, {e, 24'h0});
                end
            end
        end
        hread(2'd0, d);
        check("R6 index after reading all", d, 32'h0);

        // R4 wrap 255 -> 0
        hwrite(2'd0, 8'hFF, 24'h0);
        hwrite(2'd1, 8'h11, 0); hwrite(2'd1, 8'h22, 0); hwrite(2'd1, 8'h33, 0);
        hwrite(2'd1, 8'h44, 0); hwrite(2'd1, 8'h55, 0); hwrite(2'd1, 8'h66, 0);
        exp_tbl[255] = 24'h112233; exp_tbl[0] = 24'h445566;
        pixel(8'hFF, 2'd0, v); check("R4 entry 255", {8'h0, v}, {8'h0, exp_tbl[255]});
        pixel(8'h00, 2'd0, v); check("R4 entry 0 after wrap", {8'h0, v}, {8'h0, exp_tbl[0]});
        hread(2'd0, d); check("R4 index after wrap", d, 32'h01000000);

        // R5 index write drops partial triple
        hwrite(2'd0, 8'd10, 0);
        hwrite(2'd1, 8'h77, 0); hwrite(2'd1, 8'h88, 0);
        hwrite(2'd0, 8'd10, 0);
        hwrite(2'd1, 8'h01, 0); hwrite(2'd1, 8'h02, 0); hwrite(2'd1, 8'h03, 0);
        exp_tbl[10] = 24'h010203;
        pixel(8'd10, 2'd0, v); check("R5 restart at red", {8'h0, v}, 32'h00010203);
        pixel(8'd11, 2'd0, v); check("R5 neighbour untouched", {8'h0, v}, {8'h0, exp_tbl[11]});
        hread(2'd0, d); check("R5 index after triple", d, 32'h0B000000);

        // R10 store racing pixel lookup
        hwrite(2'd0, 8'd20, 0);
        hwrite(2'd1, 8'hC1, 0); hwrite(2'd1, 8'hC2, 0);
        @(negedge clk);
        host_wr = 1; host_reg = 2'd1; host_wdata = {8'hC3, 24'h0};
        pix_index = 8'd20; pix_sel = 2'd0;
        @(negedge clk);
        host_wr = 0;
        v_old = pix_rgb;
        @(negedge clk);
        v = pix_rgb;
        check("R10 same-edge lookup shows old", {8'h0, v_old}, {8'h0, exp_tbl[20]});
        exp_tbl[20] = 24'hC1C2C3;
        check("R10 next edge shows new", {8'h0, v}, 32'h00C1C2C3);

        // R1 write and read together: write wins
        hwrite(2'd0, 8'd30, 0);
        @(negedge clk);
        host_wr = 1; host_rd = 1; host_reg = 2'd0; host_wdata = {8'd40, 24'h0};
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        check("R1 rdata held when write wins", host_rdata, 32'h0B000000);
        hread(2'd0, d); check("R1 write applied", d, 32'h28000000);

        // R8 control registers
        for (int k = 4; k < 8; k++) begin
            hwrite(2'd0, 8'(k), 0);
            hread(2'd2, d);
            check("R8 control reset zero", d, 32'h0);
        end
        hwrite(2'd0, 8'd4, 0); hwrite(2'd2, 8'hFF, 24'h00FFFF);
        hwrite(2'd0, 8'd5, 0); hwrite(2'd2, 8'h00, 0);
        hwrite(2'd0, 8'd6, 0); hwrite(2'd2, 8'h73, 0);
        hwrite(2'd0, 8'd7, 0); hwrite(2'd2, 8'h00, 0);
        check("R9 cursor_en after 0x73", {31'h0, cursor_en}, 32'h1);
        hwrite(2'd0, 8'd9, 0); hwrite(2'd2, 8'hEE, 0);
        hread(2'd2, d); check("R8 out-of-range control read", d, 32'h0);
        hread(2'd0, d); check("R8 control write keeps index", d, 32'h09000000);
        hwrite(2'd0, 8'd4, 0); hread(2'd2, d); check("R8 ctrl 4", d, 32'hFF000000);
        hwrite(2'd0, 8'd5, 0); hread(2'd2, d); check("R8 ctrl 5", d, 32'h0);
        hwrite(2'd0, 8'd7, 0); hread(2'd2, d); check("R8 ctrl 7", d, 32'h0);
        // read-modify-write of control 6
        hwrite(2'd0, 8'd6, 0); hwrite(2'd2, 8'h70, 0);
        check("R9 cursor_en cleared", {31'h0, cursor_en}, 32'h0);
        hread(2'd2, d);
        hwrite(2'd2, d[31:24] | 8'h03, 0);
        check("R9 cursor_en after set bits", {31'h0, cursor_en}, 32'h1);
        hread(2'd2, d); check("R8 ctrl 6 read-modify-write", d, 32'h73000000);

        // R7 cursor colours
        hwrite(2'd0, 8'd2, 0);
        hwrite(2'd3, 8'hAA, 0); hwrite(2'd3, 8'hBB, 0); hwrite(2'd3, 8'hCC, 0);
        hwrite(2'd3, 8'h12, 0); hwrite(2'd3, 8'h34, 0); hwrite(2'd3, 8'h56, 0);
        hread(2'd0, d); check("R7 index after two cursor triples", d, 32'h04000000);
        hread(2'd3, d); check("R7 cursor read zero", d, 32'h0);
        hwrite(2'd0, 8'd50, 0);
        hwrite(2'd3, 8'hDE, 0); hwrite(2'd3, 8'hAD, 0); hwrite(2'd3, 8'hBE, 0);
        hread(2'd0, d); check("R7 ignored cursor write keeps index", d, 32'h32000000);
        pixel(8'd50, 2'd0, v); check("R7 ignored cursor write keeps table", {8'h0, v}, {8'h0, exp_tbl[50]});
        pixel(8'd5, 2'd1, v); check("R9 sel1 cursor 0", {8'h0, v}, 32'h00AABBCC);
        pixel(8'd5, 2'd2, v); check("R9 sel2 cursor 1", {8'h0, v}, 32'h00123456);
        pixel(8'd5, 2'd3, v); check("R9 sel3 table", {8'h0, v}, {8'h0, exp_tbl[5]});
        pixel(8'd6, 2'd0, v); check("R9 sel0 table", {8'h0, v}, {8'h0, exp_tbl[6]});
        // step not disturbed by ignored cursor write: a table triple at 50
        hwrite(2'd1, 8'h0A, 0); hwrite(2'd1, 8'h0B, 0); hwrite(2'd1, 8'h0C, 0);
        exp_tbl[50] = 24'h0A0B0C;
        pixel(8'd50, 2'd0, v); check("R7 step unchanged by ignored write", {8'h0, v}, 32'h000A0B0C);
        // disable overlay
        hwrite(2'd0, 8'd6, 0); hwrite(2'd2, 8'h72, 0);
        check("R9 cursor_en low", {31'h0, cursor_en}, 32'h0);
        pixel(8'd5, 2'd1, v); check("R9 overlay off sel1", {8'h0, v}, {8'h0, exp_tbl[5]});
        pixel(8'd7, 2'd2, v); check("R9 overlay off sel2", {8'h0, v}, {8'h0, exp_tbl[7]});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule